// File: doc/BRIEF.md
# Timed Fuse and Lock Access Controller

This block guards a small configuration store made of one lock byte and two fuse bytes, a low one and a high one. Software opens access by writing an arming pattern into a control register. A program strobe or a load strobe then acts on the store, but only during a short countdown that starts at the arming write. A program strobe inside its window clears boot-lock bits from a data byte. A load strobe inside its shorter window returns the byte that a 16-bit pointer selects. The arm state clears itself once an access is taken or once the window runs out.

A load strobe outside the read window is passed on as an ordinary program-memory read and flagged on its own output. An EEPROM write in progress, shown by a busy input, blocks control writes and configuration accesses. The fuse bytes are fixed by parameters at reset. The lock byte is held in flops that start from a parameter value, and programming can only clear its bits.

Top module: `cfg_access_ctrl`

## Requirements
- R1: After reset, `ctl_q` is 0x00, `cfg_rd_vld` and `mem_rd_vld` are low, `rdata` is 0x00, and the lock byte reads back as LOCK_INIT with bits 7 and 6 forced to one.
- R2: A control write with `ctl_wdata[6:0]` equal to 0001001b arms the block, whatever bit 7 holds, and `ctl_q` reads 0x09 from the next cycle. Any other control write disarms it, and `ctl_q` reads 0x00.
- R3: A `load_stb` in one of the first 3 cycles after the arming edge is a configuration read. `cfg_rd_vld` is high in the next cycle and `rdata` then holds the selected byte.
- R4: A `prog_stb` in one of the first 4 cycles after the arming edge programs the lock byte. A `prog_stb` when the block is not armed, or after the window, leaves the lock byte unchanged.
- R5: The arm state clears in the cycle after an accepted read or program. With no accepted strobe it clears after 4 armed cycles, so `ctl_q` reads 0x00 from the 5th cycle after the arming edge.
- R6: For a configuration read, pointer 0x0000 returns the fuse low byte, 0x0001 the lock byte and 0x0003 the fuse high byte. Any other pointer returns 0xFF.
- R7: Programming clears each lock bit 5..2 whose data bit is zero. Lock bits 7, 6, 1 and 0 never change, and the pointer has no effect. The lock byte layout is: bits 7..6 read as one, bits 5..2 are the boot-lock bits, bits 1..0 are the general lock bits.
- R8: A lock bit that reads zero stays zero until reset, even when it is programmed again with a one.
- R9: While `ee_busy` is high, control writes have no effect. Program strobes and in-window load strobes produce no response and leave the arm state as it is.
- R10: A `load_stb` outside the read window raises `mem_rd_vld` for one cycle in the next cycle, and `rdata` keeps its previous value.
- R11: An arming write made while the block is already armed restarts the countdown from the full window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| prog_stb | input | 1 | Store-program strobe |
| load_stb | input | 1 | Load-program strobe |
| ptr | input | ADDR_W (16) | Address pointer |
| wdata | input | 8 | Program data byte |
| ee_busy | input | 1 | EEPROM write in progress |
| ctl_q | output | 8 | Control register readback (0x09 when armed) |
| rdata | output | 8 | Configuration byte returned by a read |
| cfg_rd_vld | output | 1 | Configuration read completed |
| mem_rd_vld | output | 1 | Load treated as a normal program-memory read |

## Verification
The in-RTL assertions check on every cycle that the window age stays in range and is zero while disarmed. They also check that the two read flags never rise together, that no lock bit ever goes from zero to one, and that the lock byte holds when no program is taken. They further check that a taken read always disarms and that a busy control write cannot arm the block. Only the bench scenarios can show the window edges: acceptance in the last read cycle and the last program cycle, rejection one cycle later, and the restart of the countdown on rearm. Only the scenarios can also show the pointer decode values and the exact bits that programming clears.

// File: rtl/cfg_access_pkg.sv
`timescale 1ns/1ps
// Shared constants for the fuse/lock access controller.
// Assumes: the arming pattern ignores bit 7 of the control write.
package cfg_access_pkg;
    // Low seven bits that arm lock/fuse access (lock-set bit 3, enable bit 0)
    localparam logic [7:0] ARM_PATTERN = 8'h09;
    localparam logic [7:0] ARM_MASK    = 8'h7F;
    // Lock bits that software programming may never touch
    localparam logic [7:0] LOCK_KEEP   = 8'hC3;
    // Readback value of an undecoded pointer
    localparam logic [7:0] UNMAPPED    = 8'hFF;
endpackage

// File: rtl/cfg_arm_window.sv
`timescale 1ns/1ps
// Arm flag plus countdown of the access window.
// Assumes: arm_wr/disarm_wr/take are already qualified by the caller;
// READ_WIN <= PROG_WIN. The arm clears after PROG_WIN armed cycles.
module cfg_arm_window #(
    parameter int PROG_WIN = 4,
    parameter int READ_WIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_wr,
    input  logic disarm_wr,
    input  logic take,
    output logic armed,
    output logic prog_open,
    output logic read_open
);
    localparam int CW = $clog2(PROG_WIN + 1);
    localparam logic [CW-1:0] LAST_AGE = CW'(PROG_WIN - 1);

    logic          armed_q;
    logic [CW-1:0] age_q;

    // Arm, restart, disarm or age the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            age_q   <= '0;
        end else if (arm_wr) begin
            armed_q <= 1'b1;
            age_q   <= '0;
        end else if (disarm_wr || take) begin
            armed_q <= 1'b0;
            age_q   <= '0;
        end else if (armed_q) begin
            if (age_q == LAST_AGE) begin
                armed_q <= 1'b0;
                age_q   <= '0;
            end else begin
                age_q <= age_q + 1'b1;
            end
        end
    end

    assign armed     = armed_q;
    assign prog_open = armed_q && (age_q < CW'(PROG_WIN));
    assign read_open = armed_q && (age_q < CW'(READ_WIN));

    // R5
    age_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        age_q <= LAST_AGE);
    // R5
    idle_age_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> age_q == '0);
endmodule

// File: rtl/cfg_store.sv
`timescale 1ns/1ps
// Lock byte flops, fixed fuse bytes and pointer decode.
// Assumes: prog_en is a single qualified pulse; programming only clears
// bits 5..2; the fuse bytes are constant after reset.
module cfg_store #(
    parameter int          ADDR_W       = 16,
    parameter logic [7:0]  LOCK_INIT    = 8'hFF,
    parameter logic [7:0]  FUSE_LO_INIT = 8'h62,
    parameter logic [7:0]  FUSE_HI_INIT = 8'hDF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] ptr,
    output logic [7:0]        sel_byte
);
    import cfg_access_pkg::*;

    localparam logic [ADDR_W-1:0] PTR_FLO  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] PTR_LOCK = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] PTR_FHI  = ADDR_W'(3);
    localparam logic [7:0]        LOCK_RST = LOCK_INIT | 8'hC0;

    logic [7:0] lock_q;

    // Clear boot-lock bits whose data bit is zero; protected bits stay
    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= LOCK_RST;
        else if (prog_en) lock_q <= lock_q & (wdata | LOCK_KEEP);
    end

    // Select the addressed configuration byte
    always_comb begin
        if (ptr == PTR_FLO)       sel_byte = FUSE_LO_INIT;
        else if (ptr == PTR_LOCK) sel_byte = lock_q;
        else if (ptr == PTR_FHI)  sel_byte = FUSE_HI_INIT;
        else                      sel_byte = UNMAPPED;
    end

    // R8
    lock_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q & ~$past(lock_q)) == 8'h00);
    // R4
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en |=> $stable(lock_q));
endmodule

// File: rtl/cfg_access_ctrl.sv
`timescale 1ns/1ps
// Top of the timed fuse/lock access controller.
// Qualifies control writes and strobes against the window and the
// EEPROM busy flag, and registers the read results.
// Assumes: prog_stb and load_stb are not asserted in the same cycle.
module cfg_access_ctrl #(
    parameter int         ADDR_W       = 16,
    parameter int         PROG_WIN     = 4,
    parameter int         READ_WIN     = 3,
    parameter logic [7:0] LOCK_INIT    = 8'hFF,
    parameter logic [7:0] FUSE_LO_INIT = 8'h62,
    parameter logic [7:0] FUSE_HI_INIT = 8'hDF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_wdata,
    input  logic              prog_stb,
    input  logic              load_stb,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [7:0]        wdata,
    input  logic              ee_busy,
    output logic [7:0]        ctl_q,
    output logic [7:0]        rdata,
    output logic              cfg_rd_vld,
    output logic              mem_rd_vld
);
    import cfg_access_pkg::*;

    logic armed, prog_open, read_open;
    logic ctl_ok, pat_hit, arm_wr, disarm_wr;
    logic prog_take, rd_take, mem_req;
    logic [7:0] sel_byte;

    assign ctl_ok    = ctl_wr && !ee_busy;
    assign pat_hit   = (ctl_wdata & ARM_MASK) == ARM_PATTERN;
    assign arm_wr    = ctl_ok && pat_hit;
    assign disarm_wr = ctl_ok && !pat_hit;
    assign prog_take = prog_stb && prog_open && !ee_busy;
    assign rd_take   = load_stb && read_open && !ee_busy;
    assign mem_req   = load_stb && !read_open;

    cfg_arm_window #(.PROG_WIN(PROG_WIN), .READ_WIN(READ_WIN)) win_i (
        .clk(clk), .rst_n(rst_n),
        .arm_wr(arm_wr), .disarm_wr(disarm_wr), .take(prog_take || rd_take),
        .armed(armed), .prog_open(prog_open), .read_open(read_open)
    );

    cfg_store #(
        .ADDR_W(ADDR_W), .LOCK_INIT(LOCK_INIT),
        .FUSE_LO_INIT(FUSE_LO_INIT), .FUSE_HI_INIT(FUSE_HI_INIT)
    ) store_i (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_take),
        .wdata(wdata), .ptr(ptr), .sel_byte(sel_byte)
    );

    assign ctl_q = armed ? ARM_PATTERN : 8'h00;

    // Register read results and the normal-read flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata      <= 8'h00;
            cfg_rd_vld <= 1'b0;
            mem_rd_vld <= 1'b0;
        end else begin
            cfg_rd_vld <= rd_take;
            mem_rd_vld <= mem_req;
            if (rd_take) rdata <= sel_byte;
        end
    end

    // R10
    rd_kind_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_rd_vld, mem_rd_vld}));
    // R5
    read_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && !ctl_wr) |=> ctl_q == 8'h00);
    // R9
    busy_no_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ee_busy && ctl_q == 8'h00) |=> ctl_q == 8'h00);
    // R10
    idle_load_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && ctl_q == 8'h00) |=> mem_rd_vld);
    // R3
    cfg_vld_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_vld |-> ($past(load_stb) && !$past(ee_busy)));
endmodule

// File: tb/cfg_access_ctrl_tb_top.sv
`timescale 1ns/1ps
module cfg_access_ctrl_tb_top;
    localparam logic [7:0] FLO = 8'h62;
    localparam logic [7:0] FHI = 8'hDF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0, prog_stb = 1'b0, load_stb = 1'b0, ee_busy = 1'b0;
    logic [7:0]  ctl_wdata = 8'h00, wdata = 8'h00;
    logic [15:0] ptr = 16'h0000;
    logic [7:0]  ctl_q, rdata;
    logic        cfg_rd_vld, mem_rd_vld;

    int    vectors = 0;
    int    misses  = 0;
    bit    done    = 1'b0;
    string cur_req = "R1";

    // reference model state
    bit       m_armed = 0;
    int       m_age   = 0;
    bit [7:0] m_lock  = 8'hFF;
    bit [7:0] m_rdata = 8'h00;
    bit       m_cfg   = 0;
    bit       m_mem   = 0;

    always #10 clk = ~clk;

    cfg_access_ctrl #(.LOCK_INIT(8'hFF), .FUSE_LO_INIT(FLO), .FUSE_HI_INIT(FHI)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .prog_stb(prog_stb), .load_stb(load_stb), .ptr(ptr), .wdata(wdata),
        .ee_busy(ee_busy), .ctl_q(ctl_q), .rdata(rdata),
        .cfg_rd_vld(cfg_rd_vld), .mem_rd_vld(mem_rd_vld)
    );

    function automatic bit [7:0] pick(input bit [15:0] p, input bit [7:0] lk);
        case (p)
            16'h0000: return FLO;
            16'h0001: return lk;
            16'h0003: return FHI;
            default:  return 8'hFF;
        endcase
    endfunction

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        bit rok, pok, took;
        if (!rst_n) begin
            m_armed = 0; m_age = 0; m_lock = 8'hFF; m_rdata = 0; m_cfg = 0; m_mem = 0;
        end else begin
            rok  = m_armed && m_age < 3;
            pok  = m_armed && m_age < 4;
            took = 0;
            m_cfg = 0; m_mem = 0;
            if (load_stb && rok && !ee_busy) begin
                m_cfg = 1; m_rdata = pick(ptr, m_lock); took = 1;
            end else if (load_stb && !rok) m_mem = 1;
            if (prog_stb && pok && !ee_busy) begin
                for (int b = 2; b <= 5; b++) if (!wdata[b]) m_lock[b] = 1'b0;
                took = 1;
            end
            if (ctl_wr && !ee_busy && ctl_wdata[6:0] == 7'b0001001) begin
                m_armed = 1; m_age = 0;
            end else if (ctl_wr && !ee_busy) m_armed = 0;
            else if (took) m_armed = 0;
            else if (m_armed) begin
                if (m_age == 3) m_armed = 0; else m_age++;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, "ctl_q", ctl_q, m_armed ? 8'h09 : 8'h00);
            chk(cur_req, "rdata", rdata, m_rdata);
            chk(cur_req, "cfg_rd_vld", {7'd0, cfg_rd_vld}, {7'd0, m_cfg});
            chk(cur_req, "mem_rd_vld", {7'd0, mem_rd_vld}, {7'd0, m_mem});
        end
    end

    task automatic cyc(input bit cw, input bit [7:0] cd, input bit pg, input bit ld,
                       input bit [7:0] wd, input bit [15:0] p, input bit bz);
        ctl_wr = cw; ctl_wdata = cd; prog_stb = pg; load_stb = ld;
        wdata = wd; ptr = p; ee_busy = bz;
        @(negedge clk);
        ctl_wr = 0; prog_stb = 0; load_stb = 0;
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 8'h00, 16'h0, 0);
    endtask
    task automatic arm();
        cyc(1, 8'h09, 0, 0, 8'h00, 16'h0, 0);
    endtask
    task automatic rd(input bit [15:0] p);
        cyc(0, 0, 0, 1, 8'h00, p, 0);
    endtask
    task automatic pgm(input bit [7:0] wd, input bit [15:0] p);
        cyc(0, 0, 1, 0, wd, p, 0);
    endtask

    initial begin
        #4_000_000;
        misses++;
        $display("FAIL watchdog: run did not finish");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1", "reset ctl_q", ctl_q, 8'h00);
        chk("R1", "reset rdata", rdata, 8'h00);
        chk("R1", "reset vld", {6'd0, cfg_rd_vld, mem_rd_vld}, 8'h00);

        cur_req = "R3";
        arm(); chk("R2", "armed", ctl_q, 8'h09);
        rd(16'h0000);
        chk("R3", "read vld", {7'd0, cfg_rd_vld}, 8'h01);
        chk("R6", "fuse low", rdata, FLO);
        chk("R5", "disarm after read", ctl_q, 8'h00);

        arm(); idle(2); rd(16'h0003);
        chk("R3", "last read cycle", {7'd0, cfg_rd_vld}, 8'h01);
        chk("R6", "fuse high", rdata, FHI);

        cur_req = "R10";
        arm(); idle(3); rd(16'h0001);
        chk("R10", "late load is mem read", {7'd0, mem_rd_vld}, 8'h01);
        chk("R10", "rdata kept", rdata, FHI);
        chk("R5", "expired", ctl_q, 8'h00);

        cur_req = "R5";
        arm(); idle(3);
        chk("R5", "still armed at 4th cycle", ctl_q, 8'h09);
        idle(1);
        chk("R5", "auto clear", ctl_q, 8'h00);

        cur_req = "R4";
        arm(); idle(3); pgm(8'hEF, 16'h1234);
        chk("R5", "disarm after program", ctl_q, 8'h00);
        arm(); rd(16'h0001);
        chk("R4", "last program cycle", rdata, 8'hEF);

        arm(); idle(4); pgm(8'hC3, 16'h0001);
        pgm(8'hC3, 16'h0001);
        arm(); rd(16'h0001);
        chk("R4", "expired/unarmed program ignored", rdata, 8'hEF);

        cur_req = "R7";
        arm(); pgm(8'hFB, 16'h0000);
        arm(); rd(16'h0001);
        chk("R7", "bit2 cleared", rdata, 8'hEB);

        cur_req = "R8";
        arm(); pgm(8'hFF, 16'h0001);
        arm(); rd(16'h0001);
        chk("R8", "no 0->1", rdata, 8'hEB);

        cur_req = "R9";
        cyc(1, 8'h09, 0, 0, 8'h00, 16'h0, 1);
        chk("R9", "busy blocks arm", ctl_q, 8'h00);
        arm(); cyc(0, 0, 1, 0, 8'h00, 16'h0, 1);
        chk("R9", "busy program keeps arm", ctl_q, 8'h09);
        cyc(0, 0, 0, 1, 8'h00, 16'h0001, 1);
        chk("R9", "busy read no response", {6'd0, cfg_rd_vld, mem_rd_vld}, 8'h00);
        chk("R9", "busy read keeps arm", ctl_q, 8'h09);
        rd(16'h0001);
        chk("R9", "busy program ignored", rdata, 8'hEB);
        arm(); cyc(1, 8'h01, 0, 0, 8'h00, 16'h0, 1);
        chk("R9", "busy disarm write ignored", ctl_q, 8'h09);
        idle(4);

        cur_req = "R7";
        arm(); pgm(8'h00, 16'h0003);
        arm(); rd(16'h0001);
        chk("R7", "only bits 5..2 cleared", rdata, 8'hC3);

        cur_req = "R6";
        arm(); rd(16'h0002);
        chk("R6", "unmapped 0002", rdata, 8'hFF);
        arm(); rd(16'h0100);
        chk("R6", "unmapped 0100", rdata, 8'hFF);

        cur_req = "R11";
        arm(); idle(3); arm(); idle(2); rd(16'h0000);
        chk("R11", "rearm restarts read window", {7'd0, cfg_rd_vld}, 8'h01);
        arm(); idle(2); arm(); idle(3);
        chk("R11", "rearm restarts expiry", ctl_q, 8'h09);
        idle(1);

        cur_req = "R2";
        arm(); cyc(1, 8'h01, 0, 0, 8'h00, 16'h0, 0);
        chk("R2", "other write disarms", ctl_q, 8'h00);
        cyc(1, 8'h89, 0, 0, 8'h00, 16'h0, 0);
        chk("R2", "bit7 ignored", ctl_q, 8'h09);
        cyc(1, 8'h0B, 0, 0, 8'h00, 16'h0, 0);
        chk("R2", "near pattern disarms", ctl_q, 8'h00);

        cur_req = "R10";
        rd(16'h0000);
        chk("R10", "unarmed load", {7'd0, mem_rd_vld}, 8'h01);
        idle(1);
        chk("R10", "one cycle pulse", {7'd0, mem_rd_vld}, 8'h00);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule